// File: doc/BRIEF.md
# Dual-Compare Up-Counting Timer

This block is a 16-bit timer that counts upward from zero and is programmed through a small byte/halfword register window. Compare register A sets the period. When counting is switched on, the block captures compare A, restarts the count at zero, and wraps back to zero each time the count reaches that captured value. Each wrap produces a one-cycle period pulse. A second compare register B produces its own one-cycle pulse whenever the count passes its value.

Control is held in two mode bytes. The run byte holds count enable and a load bit. The configuration byte holds general settings. Two single-byte compare-mode registers decide whether the compare A and compare B pulses are emitted at all. Any write that breaks a size or reserved-bit rule is dropped entirely and sets a sticky error flag. Reads are combinational and return the addressed register right-justified.

Top module: `timer16_dualcmp`

## Requirements
- R1: After reset the counter, both mode bytes, both compare-mode bytes and both compare registers read as zero, all three event outputs are low and `errFlag` is low.
- R2: A legal write of the run byte (offset 0x85 as a byte, or bits 7:0 of a halfword at 0x84) with bit 7 set does the following: it captures compare A as the period, clears the counter on that clock edge, and makes the counter advance by one per clock. If compare A is zero, the counter does not run and reads zero.
- R3: While running, the counter goes 0,1,…,P and then back to 0. `periodEvt` is high for exactly the one cycle in which the counter shows 0 after a wrap, so it pulses every P+1 clocks. Writing compare A while the counter runs does not change P.
- R4: `cmpAEvt` pulses in the same cycles as `periodEvt`, but only while bit 0 of the compare-A mode byte (offset 0xB4) is 1.
- R5: `cmpBEvt` pulses for one cycle, one clock after the counter equals compare B. This happens only while bit 0 of the compare-B mode byte (offset 0xB5) is 1 and compare B is no larger than P.
- R6: A legal run-byte write with bit 7 clear stops the counter, makes it read zero, and cancels any pulse that was due on that edge. No further pulses occur until the next start.
- R7: Mode-byte legality rules. In the configuration byte (0x84), bits 5, 3 and 2 must be zero. In the run byte, bits 7 and 6 must not both be set, and bits 2:0 must be zero. A halfword access to the mode pair is legal only at 0x84.
- R8: `size` encodes 0 = byte and 1 = halfword; 2 and 3 are illegal. The counter (0xA4) is read-only. The compare-mode bytes accept byte writes only. Compare A (0xC4) and compare B (0xD4) accept byte or halfword writes, and a byte write zero-extends. A write to any other offset is illegal.
- R9: An illegal write changes no register and sets `errFlag`, which stays set until reset.
- R10: A halfword read at 0x84 returns the configuration byte in bits 15:8 and the run byte in bits 7:0. Byte reads return the value in bits 7:0. A read of an unmapped offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the current address/size/data |
| addr | input | 8 | Register offset |
| size | input | 2 | Access size: 0 byte, 1 halfword |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Combinational read data |
| errFlag | output | 1 | Sticky illegal-write flag |
| periodEvt | output | 1 | One-cycle pulse on each wrap |
| cmpAEvt | output | 1 | One-cycle compare-A pulse |
| cmpBEvt | output | 1 | One-cycle compare-B pulse |

## Verification
The counter is run with several period/compare pairs. The shortest nonzero period with compare B equal to it checks the boundary where both events coincide. A mid-size period with compare B inside it separates the B pulse from the wrap. A compare B above the period must stay silent. A compare B of zero must fire on the cycle right after start. A period of zero must never run. One run rewrites compare A mid-flight, which separates a captured period from a live one. Another run starts counting through a halfword mode write. Every pulse is matched against a queue of expected cycle numbers, so a pulse that is late, extra or missing is caught. Each illegal write is followed by a read-back that shows the targeted register did not change.

// File: rtl/timer16_pkg.sv
package timer16_pkg;
  parameter int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] ADR_MODE_CFG = 8'h84;
  localparam logic [ADDR_W-1:0] ADR_MODE_RUN = 8'h85;
  localparam logic [ADDR_W-1:0] ADR_COUNT    = 8'hA4;
  localparam logic [ADDR_W-1:0] ADR_CMD_A    = 8'hB4;
  localparam logic [ADDR_W-1:0] ADR_CMD_B    = 8'hB5;
  localparam logic [ADDR_W-1:0] ADR_CMP_A    = 8'hC4;
  localparam logic [ADDR_W-1:0] ADR_CMP_B    = 8'hD4;

  localparam logic [BYTE_W-1:0] CFG_RSVD = 8'h2C;
  localparam logic [BYTE_W-1:0] RUN_RSVD = 8'h07;
  localparam int RUN_EN_BIT   = 7;
  localparam int RUN_LOAD_BIT = 6;

  typedef struct packed {
    logic             start;
    logic             stop;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] matchB;
    logic             evtAOn;
    logic             evtBOn;
  } ctrlStb_t;

  function automatic logic cfgOk(input logic [BYTE_W-1:0] b);
    return (b & CFG_RSVD) == '0;
  endfunction

  function automatic logic runOk(input logic [BYTE_W-1:0] b);
    return ((b & RUN_RSVD) == '0) && !(b[RUN_EN_BIT] && b[RUN_LOAD_BIT]);
  endfunction

  function automatic logic [CNT_W-1:0] zext(input logic [BYTE_W-1:0] b);
    return {{(CNT_W-BYTE_W){1'b0}}, b};
  endfunction
endpackage

// File: rtl/timer16_regs.sv
module timer16_regs
  import timer16_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [CNT_W-1:0]  wdata,
  input  logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  rdata,
  output logic              errFlag,
  output ctrlStb_t          stb
);
  logic [BYTE_W-1:0] modeCfg, modeRun, cmdA, cmdB;
  logic [CNT_W-1:0]  cmpA, cmpB;

  logic isByte, isHalf;
  logic wrCfg, wrRun, wrCmdA, wrCmdB, wrCmpA, wrCmpB, bad;
  logic [BYTE_W-1:0] nCfg, nRun;
  logic [CNT_W-1:0]  nCmp;

  assign isByte = (size == 2'd0);
  assign isHalf = (size == 2'd1);

  always_comb begin
    wrCfg = 1'b0; wrRun = 1'b0; wrCmdA = 1'b0; wrCmdB = 1'b0;
    wrCmpA = 1'b0; wrCmpB = 1'b0; bad = 1'b0;
    nCfg = wdata[BYTE_W-1:0];
    nRun = wdata[BYTE_W-1:0];
    nCmp = isHalf ? wdata : zext(wdata[BYTE_W-1:0]);
    if (wrEn) begin
      if (!isByte && !isHalf) begin
        bad = 1'b1;
      end else begin
        case (addr)
          ADR_MODE_CFG: begin
            if (isHalf) begin
              nCfg = wdata[CNT_W-1:BYTE_W];
              if (cfgOk(nCfg) && runOk(nRun)) begin
                wrCfg = 1'b1;
                wrRun = 1'b1;
              end else bad = 1'b1;
            end else if (cfgOk(nCfg)) wrCfg = 1'b1;
            else bad = 1'b1;
          end
          ADR_MODE_RUN: if (isByte && runOk(nRun)) wrRun = 1'b1; else bad = 1'b1;
          ADR_CMD_A:    if (isByte) wrCmdA = 1'b1; else bad = 1'b1;
          ADR_CMD_B:    if (isByte) wrCmdB = 1'b1; else bad = 1'b1;
          ADR_CMP_A:    wrCmpA = 1'b1;
          ADR_CMP_B:    wrCmpB = 1'b1;
          default:      bad = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeCfg <= '0; modeRun <= '0; cmdA <= '0; cmdB <= '0;
      cmpA <= '0; cmpB <= '0; errFlag <= 1'b0;
    end else begin
      if (wrCfg)  modeCfg <= nCfg;
      if (wrRun)  modeRun <= nRun;
      if (wrCmdA) cmdA <= wdata[BYTE_W-1:0];
      if (wrCmdB) cmdB <= wdata[BYTE_W-1:0];
      if (wrCmpA) cmpA <= nCmp;
      if (wrCmpB) cmpB <= nCmp;
      if (bad)    errFlag <= 1'b1;
    end
  end

  always_comb begin
    stb.start  = wrRun && nRun[RUN_EN_BIT];
    stb.stop   = wrRun && !nRun[RUN_EN_BIT];
    stb.period = cmpA;
    stb.matchB = cmpB;
    stb.evtAOn = cmdA[0];
    stb.evtBOn = cmdB[0];
  end

  always_comb begin
    rdata = '0;
    if (isByte || isHalf) begin
      case (addr)
        ADR_MODE_CFG: rdata = isHalf ? {modeCfg, modeRun} : zext(modeCfg);
        ADR_MODE_RUN: rdata = isByte ? zext(modeRun) : '0;
        ADR_COUNT:    rdata = isHalf ? cnt : zext(cnt[BYTE_W-1:0]);
        ADR_CMD_A:    rdata = isByte ? zext(cmdA) : '0;
        ADR_CMD_B:    rdata = isByte ? zext(cmdB) : '0;
        ADR_CMP_A:    rdata = isHalf ? cmpA : zext(cmpA[BYTE_W-1:0]);
        ADR_CMP_B:    rdata = isHalf ? cmpB : zext(cmpB[BYTE_W-1:0]);
        default:      rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/timer16_dp.sv
module timer16_dp
  import timer16_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStb_t         stb,
  output logic [CNT_W-1:0] cnt,
  output logic             running,
  output logic [CNT_W-1:0] period,
  output logic             periodEvt,
  output logic             cmpAEvt,
  output logic             cmpBEvt
);
  logic atTop;
  assign atTop = (cnt == period);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0; running <= 1'b0; period <= '0;
      periodEvt <= 1'b0; cmpAEvt <= 1'b0; cmpBEvt <= 1'b0;
    end else begin
      periodEvt <= 1'b0;
      cmpAEvt   <= 1'b0;
      cmpBEvt   <= 1'b0;
      if (stb.stop) begin
        running <= 1'b0;
        cnt     <= '0;
      end else if (stb.start) begin
        running <= (stb.period != '0);
        period  <= stb.period;
        cnt     <= '0;
      end else if (running) begin
        periodEvt <= atTop;
        cmpAEvt   <= atTop && stb.evtAOn;
        cmpBEvt   <= stb.evtBOn && (cnt == stb.matchB) && (stb.matchB <= period);
        cnt       <= atTop ? '0 : cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/timer16_dualcmp.sv
module timer16_dualcmp
  import timer16_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              errFlag,
  output logic              periodEvt,
  output logic              cmpAEvt,
  output logic              cmpBEvt
);
  ctrlStb_t         stb;
  logic [CNT_W-1:0] cntVal;
  logic [CNT_W-1:0] perVal;
  logic             runVal;

  timer16_regs u_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .size(size),
    .wdata(wdata), .cnt(cntVal), .rdata(rdata), .errFlag(errFlag), .stb(stb)
  );

  timer16_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cnt(cntVal), .running(runVal),
    .period(perVal), .periodEvt(periodEvt), .cmpAEvt(cmpAEvt), .cmpBEvt(cmpBEvt)
  );
endmodule

// File: rtl/timer16_chk.sv
module timer16_chk
  import timer16_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             stbStart,
  input logic             stbStop,
  input logic [CNT_W-1:0] cnt,
  input logic             running,
  input logic [CNT_W-1:0] period,
  input logic             errFlag,
  input logic             periodEvt,
  input logic             cmpAEvt,
  input logic             cmpBEvt
);
  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && !stbStart && !stbStop && cnt != period) |=> (cnt == $past(cnt) + 1'b1));

  // R3
  period_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    periodEvt |=> !periodEvt);

  // R4
  cmpa_with_period_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmpAEvt |-> periodEvt);

  // R5
  cmpb_running_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmpBEvt |-> $past(running));

  // R6
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    stbStop |=> (cnt == '0 && !running && !periodEvt && !cmpAEvt && !cmpBEvt));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);
endmodule

bind timer16_dualcmp timer16_chk u_chk (
  .clk(clk), .rstN(rstN), .stbStart(stb.start), .stbStop(stb.stop),
  .cnt(cntVal), .running(runVal), .period(perVal), .errFlag(errFlag),
  .periodEvt(periodEvt), .cmpAEvt(cmpAEvt), .cmpBEvt(cmpBEvt)
);

// File: tb/timer16_dualcmp_test.sv
`timescale 1ns/1ps
module timer16_dualcmp_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [1:0]  size = 2'd0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic        errFlag, periodEvt, cmpAEvt, cmpBEvt;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  int qP[$];
  int qA[$];
  int qB[$];

  timer16_dualcmp uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .size(size), .wdata(wdata),
    .rdata(rdata), .errFlag(errFlag), .periodEvt(periodEvt), .cmpAEvt(cmpAEvt),
    .cmpBEvt(cmpBEvt)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; size = s; wdata = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [1:0] s, output int v);
    @(negedge clk);
    addr = a; size = s;
    #1 v = int'(rdata);
  endtask

  // monitor: pops expected pulse cycle numbers
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (periodEvt) begin
        if (qP.size() > 0 && qP[0] == cyc) begin void'(qP.pop_front()); chk(1, "R3", 1, 1); end
        else chk(0, "R3 unexpected period pulse at cycle", cyc, (qP.size() > 0) ? qP[0] : -1);
      end else if (qP.size() > 0 && qP[0] == cyc) begin
        void'(qP.pop_front()); chk(0, "R3 missing period pulse at cycle", 0, cyc);
      end
      if (cmpAEvt) begin
        if (qA.size() > 0 && qA[0] == cyc) begin void'(qA.pop_front()); chk(1, "R4", 1, 1); end
        else chk(0, "R4 unexpected compare-A pulse at cycle", cyc, (qA.size() > 0) ? qA[0] : -1);
      end else if (qA.size() > 0 && qA[0] == cyc) begin
        void'(qA.pop_front()); chk(0, "R4 missing compare-A pulse at cycle", 0, cyc);
      end
      if (cmpBEvt) begin
        if (qB.size() > 0 && qB[0] == cyc) begin void'(qB.pop_front()); chk(1, "R5", 1, 1); end
        else chk(0, "R5 unexpected compare-B pulse at cycle", cyc, (qB.size() > 0) ? qB[0] : -1);
      end else if (qB.size() > 0 && qB[0] == cyc) begin
        void'(qB.pop_front()); chk(0, "R5 missing compare-B pulse at cycle", 0, cyc);
      end
    end
  end

  // driver: program, start, push expectations, stop
  task automatic runSeg(input int pA, input int pB, input bit aOn, input bit bOn,
                        input int len, input int newA, input bit useHalf);
    int s, t, v;
    wr(8'hC4, 2'd1, 16'(pA));
    wr(8'hD4, 2'd1, 16'(pB));
    wr(8'hB4, 2'd0, {15'd0, aOn});
    wr(8'hB5, 2'd0, {15'd0, bOn});
    if (useHalf) wr(8'h84, 2'd1, 16'h1180);
    else         wr(8'h85, 2'd0, 16'h0080);
    s = cyc;
    t = s + len;
    for (int c = s + 1 + pA; c < t; c += pA + 1) begin
      qP.push_back(c);
      if (aOn) qA.push_back(c);
    end
    if (bOn && pB <= pA)
      for (int c = s + 1 + pB; c < t; c += pA + 1) qB.push_back(c);
    rd(8'hA4, 2'd1, v);
    chk(v == (cyc - s) % (pA + 1), "R2 counter value while running", v, (cyc - s) % (pA + 1));
    if (useHalf) begin
      rd(8'h84, 2'd1, v);
      chk(v == 16'h1180, "R10 halfword mode read", v, 16'h1180);
    end
    if (newA != 0) wr(8'hC4, 2'd1, 16'(newA));
    while (cyc < t - 2) @(negedge clk);
    wr(8'h85, 2'd0, 16'h0000);
    repeat (4) @(negedge clk);
    chk(qP.size() == 0 && qA.size() == 0 && qB.size() == 0, "R6 pulses left after stop",
        qP.size() + qA.size() + qB.size(), 0);
    rd(8'hA4, 2'd1, v);
    chk(v == 0, "R6 counter after stop", v, 0);
  endtask

  task automatic badWr(input logic [7:0] a, input logic [1:0] s, input logic [15:0] d,
                       input logic [7:0] ra, input logic [1:0] rs, input int exp, input string tag);
    int v;
    wr(a, s, d);
    rd(ra, rs, v);
    chk(v == exp, tag, v, exp);
    chk(errFlag == 1'b1, "R9 error flag set", int'(errFlag), 1);
  endtask

  initial begin
    #(100000 * 4);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rd(8'hA4, 2'd1, v); chk(v == 0, "R1 counter at reset", v, 0);
    rd(8'h84, 2'd1, v); chk(v == 0, "R1 mode pair at reset", v, 0);
    rd(8'hC4, 2'd1, v); chk(v == 0, "R1 compare A at reset", v, 0);
    chk(!periodEvt && !cmpAEvt && !cmpBEvt, "R1 events low", int'(periodEvt), 0);
    chk(errFlag == 1'b0, "R1 error flag", int'(errFlag), 0);

    runSeg(5, 2, 1, 1, 30, 0, 0);   // R3 R4 R5 mid-size period
    runSeg(3, 7, 0, 1, 20, 0, 0);   // R5 B above period, R4 A disabled
    runSeg(1, 1, 1, 1, 20, 0, 1);   // R3 R5 minimum period, B equals A, halfword start
    runSeg(2, 0, 1, 1, 20, 0, 0);   // R5 B zero
    runSeg(4, 3, 1, 1, 30, 9, 0);   // R3 compare A rewritten mid-run

    // R2 zero period never runs
    wr(8'hC4, 2'd1, 16'h0000);
    wr(8'h85, 2'd0, 16'h0080);
    repeat (6) @(negedge clk);
    rd(8'hA4, 2'd1, v); chk(v == 0, "R2 zero period counter", v, 0);
    wr(8'h85, 2'd0, 16'h0000);

    // R8 byte write to compare zero-extends
    wr(8'hD4, 2'd1, 16'hABCD);
    wr(8'hD4, 2'd0, 16'hFF12);
    rd(8'hD4, 2'd1, v); chk(v == 16'h0012, "R8 byte compare write zero-extends", v, 16'h0012);
    // R10 reads
    rd(8'h40, 2'd0, v); chk(v == 0, "R10 unmapped read", v, 0);
    rd(8'hD4, 2'd0, v); chk(v == 16'h0012, "R10 byte read", v, 16'h0012);
    chk(errFlag == 1'b0, "R9 no error before illegal writes", int'(errFlag), 0);

    // legal setup for illegal-write checks
    wr(8'h84, 2'd0, 16'h0011);
    wr(8'h85, 2'd0, 16'h0040);
    wr(8'hC4, 2'd1, 16'h0006);
    wr(8'hB4, 2'd0, 16'h0001);
    rd(8'h84, 2'd1, v); chk(v == 16'h1140, "R10 mode pair read", v, 16'h1140);
    chk(errFlag == 1'b0, "R7 legal mode values accepted", int'(errFlag), 0);

    badWr(8'h84, 2'd0, 16'h0004, 8'h84, 2'd0, 16'h0011, "R7 cfg reserved bit");
    badWr(8'h84, 2'd0, 16'h0020, 8'h84, 2'd0, 16'h0011, "R7 cfg reserved bit 5");
    badWr(8'h85, 2'd0, 16'h00C0, 8'h85, 2'd0, 16'h0040, "R7 enable with load");
    badWr(8'h85, 2'd0, 16'h0081, 8'h85, 2'd0, 16'h0040, "R7 run reserved bit");
    badWr(8'h85, 2'd1, 16'h0080, 8'h85, 2'd0, 16'h0040, "R7 halfword at second byte");
    badWr(8'h84, 2'd1, 16'h0081, 8'h84, 2'd1, 16'h1140, "R7 halfword with bad run byte");
    badWr(8'hA4, 2'd1, 16'h0055, 8'hA4, 2'd1, 0, "R8 counter write");
    badWr(8'hC4, 2'd2, 16'h0033, 8'hC4, 2'd1, 16'h0006, "R8 word size write");
    badWr(8'hB4, 2'd1, 16'h0000, 8'hB4, 2'd0, 16'h0001, "R8 halfword compare-mode write");
    badWr(8'h40, 2'd0, 16'h0077, 8'h40, 2'd0, 0, "R8 unmapped write");
    repeat (4) @(negedge clk);
    chk(errFlag == 1'b1, "R9 flag remains set", int'(errFlag), 1);
    chk(qP.size() == 0, "R7 no start from rejected write", qP.size(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule